// File: doc/BRIEF.md
# Mode-Selected Clock Output Gating

This block fans one reference clock out to two banks of clock outputs: a bank of single-ended outputs for single-data-rate memory and a bank of true/complement output pairs for double-data-rate memory. Each bank also drives one feedback clock. The reference clock input stands in for the output of an upstream phase-locked loop. Phase alignment, drive strength and supply levels are handled elsewhere.

A level-sensitive mode select picks one bank. The other bank, including its feedback clock, is held low. Inside the active bank, a per-output enable vector, normally driven by a register block, decides which outputs toggle. A cleared enable forces its output low at once, with no clock edge involved. The feedback clocks do not respond to the enables, so an external loop can always lock on the active bank. While reset is applied, all enables are treated as set, so every output of the selected bank runs. The present level of the mode select is passed straight back out for register readback.

Top module: `clkgate_top`

## Requirements
- R1: With `mode_sel` = 1, each `ddr_clk_t[i]` equals `ref_clk` when its enable is 1. All `sdr_clk` bits and `fb_sdr_clk` are low.
- R2: With `mode_sel` = 0, each `sdr_clk[i]` equals `ref_clk` when its enable is 1. All `ddr_clk_t`, `ddr_clk_c` and `fb_ddr_clk` are low.
- R3: In an active, enabled pair, `ddr_clk_c[i]` is the inverse of `ref_clk`, so it is low while `ref_clk` is high and high while `ref_clk` is low.
- R4: An enable bit of 0 drives both lines of its output low in both clock phases. A change of the bit reaches the output combinationally, without waiting for a clock edge.
- R5: The feedback clock of the selected bank follows `ref_clk` whatever the enable vectors hold.
- R6: In DDR mode (`mode_sel` = 1), the `sdr_en` bits have no effect: every `sdr_clk` stays low.
- R7: While `rst_n` is low, and for two rising `ref_clk` edges after it rises, every enable is treated as 1.
- R8: `mode_rd` equals `mode_sel` at all times. The level is not latched.
- R9: In the inactive DDR bank, both the true and the complement line of every pair are low in both clock phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock to distribute |
| rst_n | input | 1 | Asynchronous active-low reset, released on `ref_clk` |
| mode_sel | input | 1 | Bank select: 1 selects the DDR bank, 0 selects the SDR bank |
| sdr_en | input | 13 | Per-output enables for the SDR bank (bit i gates `sdr_clk[i]`) |
| ddr_en | input | 6 | Per-pair enables for the DDR bank (bit i gates pair i) |
| sdr_clk | output | 13 | Single-ended SDR clock outputs |
| ddr_clk_t | output | 6 | True lines of the DDR pairs |
| ddr_clk_c | output | 6 | Complement lines of the DDR pairs |
| fb_sdr_clk | output | 1 | SDR bank feedback clock |
| fb_ddr_clk | output | 1 | DDR bank feedback clock |
| mode_rd | output | 1 | Current mode select level for readback |

## Verification
On every falling reference edge, with the high phase sampled, the assertions check several properties. The inactive bank and its feedback clock must be quiet. The active feedback clock must be high. An enabled pair must show opposite levels on its two lines, and a cleared enable must hold its output low. The bench's scenarios are needed for three things: the immediate effect of an enable change in the middle of a phase, the enables being forced on while reset is applied and in the two cycles after release, and the low-phase behaviour of the complement lines.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int unsigned SDR_OUTS  = 13;
  localparam int unsigned DDR_PAIRS = 6;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    BANK_SDR = 1'b0,
    BANK_DDR = 1'b1
  } bank_sel_e;
endpackage

// File: rtl/clkgate_rst_sync.sv
module clkgate_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[DEPTH-1];
endmodule

// File: rtl/clkgate_se_bank.sv
module clkgate_se_bank #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk,
  input  logic             bank_on,
  input  logic [WIDTH-1:0] en,
  output logic [WIDTH-1:0] clk_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    always_comb begin
      clk_out[i] = clk & bank_on & en[i];
    end
  end
endmodule

// File: rtl/clkgate_diff_bank.sv
module clkgate_diff_bank #(
  parameter int unsigned PAIRS = 6
) (
  input  logic             clk,
  input  logic             bank_on,
  input  logic [PAIRS-1:0] en,
  output logic [PAIRS-1:0] clk_t,
  output logic [PAIRS-1:0] clk_c
);
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    logic pair_on;
    always_comb begin
      pair_on  = bank_on & en[i];
      clk_t[i] = clk & pair_on;
      clk_c[i] = ~clk & pair_on;
    end
  end
endmodule

// File: rtl/clkgate_top.sv
module clkgate_top
  import clkgate_pkg::*;
#(
  parameter int unsigned N_SDR   = SDR_OUTS,
  parameter int unsigned N_DDR   = DDR_PAIRS,
  parameter int unsigned N_SYNC  = SYNC_DEPTH
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic [N_SDR-1:0] sdr_en,
  input  logic [N_DDR-1:0] ddr_en,
  output logic [N_SDR-1:0] sdr_clk,
  output logic [N_DDR-1:0] ddr_clk_t,
  output logic [N_DDR-1:0] ddr_clk_c,
  output logic             fb_sdr_clk,
  output logic             fb_ddr_clk,
  output logic             mode_rd
);
  bank_sel_e        bank;
  logic             srst_n;
  logic             sdr_on;
  logic             ddr_on;
  logic [N_SDR-1:0] sdr_en_eff;
  logic [N_DDR-1:0] ddr_en_eff;

  clkgate_rst_sync #(.DEPTH(N_SYNC)) u_rst_sync (
    .clk   (ref_clk),
    .arst_n(rst_n),
    .srst_n(srst_n)
  );

  always_comb begin
    bank       = bank_sel_e'(mode_sel);
    sdr_on     = (bank == BANK_SDR);
    ddr_on     = (bank == BANK_DDR);
    sdr_en_eff = sdr_en | {N_SDR{~srst_n}};
    ddr_en_eff = ddr_en | {N_DDR{~srst_n}};
  end

  clkgate_se_bank #(.WIDTH(N_SDR)) u_sdr_bank (
    .clk    (ref_clk),
    .bank_on(sdr_on),
    .en     (sdr_en_eff),
    .clk_out(sdr_clk)
  );

  clkgate_diff_bank #(.PAIRS(N_DDR)) u_ddr_bank (
    .clk    (ref_clk),
    .bank_on(ddr_on),
    .en     (ddr_en_eff),
    .clk_t  (ddr_clk_t),
    .clk_c  (ddr_clk_c)
  );

  clkgate_se_bank #(.WIDTH(2)) u_fb_bank (
    .clk    (ref_clk),
    .bank_on(1'b1),
    .en     ({ddr_on, sdr_on}),
    .clk_out({fb_ddr_clk, fb_sdr_clk})
  );

  assign mode_rd = mode_sel;

  // Checked on the falling edge, so the sampled values belong to the high phase.
  a_r1_sdr_quiet: assert property (@(negedge ref_clk) disable iff (!rst_n)
    mode_sel |-> (sdr_clk == '0 && !fb_sdr_clk));
  a_r2_ddr_quiet: assert property (@(negedge ref_clk) disable iff (!rst_n)
    !mode_sel |-> (ddr_clk_t == '0 && ddr_clk_c == '0 && !fb_ddr_clk));
  a_r5_fb_ddr_runs: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (mode_sel && ddr_en == '0) |-> fb_ddr_clk);
  a_r5_fb_sdr_runs: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (!mode_sel && sdr_en == '0) |-> fb_sdr_clk);
  a_r3_pair_opposite: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (mode_sel && ddr_en[0]) |-> (ddr_clk_t[0] != ddr_clk_c[0]));
  a_r4_sdr_off_low: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (srst_n && !sdr_en[0]) |-> !sdr_clk[0]);
  a_r8_mode_echo: assert property (@(negedge ref_clk) disable iff (!rst_n)
    mode_rd == mode_sel);
endmodule

// File: tb/clkgate_top_tb_top.sv
module clkgate_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int NS = 13;
  localparam int ND = 6;

  typedef struct {
    logic [NS-1:0] sdr_hi;
    logic [ND-1:0] t_hi, c_hi, t_lo, c_lo;
    logic          fbs_hi, fbd_hi;
    string         req;
  } exp_t;

  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic [NS-1:0] sdr_en = '0;
  logic [ND-1:0] ddr_en = '0;
  logic [NS-1:0] sdr_clk;
  logic [ND-1:0] ddr_clk_t, ddr_clk_c;
  logic fb_sdr_clk, fb_ddr_clk, mode_rd;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  clkgate_top dut_i (
    .ref_clk(ref_clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .sdr_en(sdr_en), .ddr_en(ddr_en), .sdr_clk(sdr_clk),
    .ddr_clk_t(ddr_clk_t), .ddr_clk_c(ddr_clk_c),
    .fb_sdr_clk(fb_sdr_clk), .fb_ddr_clk(fb_ddr_clk), .mode_rd(mode_rd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: apply stimulus and push the expected phase values.
  task automatic drive(input logic m, input logic [NS-1:0] se, input logic [ND-1:0] de,
                       input logic forced, input string req);
    exp_t e;
    logic [NS-1:0] se_e;
    logic [ND-1:0] de_e;
    @(negedge ref_clk); #1;
    mode_sel = m; sdr_en = se; ddr_en = de;
    se_e = forced ? '1 : se;
    de_e = forced ? '1 : de;
    e.sdr_hi = m ? '0 : se_e;
    e.t_hi = m ? de_e : '0;
    e.c_hi = '0;
    e.t_lo = '0;
    e.c_lo = m ? de_e : '0;
    e.fbs_hi = !m;
    e.fbd_hi = m;
    e.req = req;
    q.push_back(e);
    pushed++;
    wait (popped == pushed);
  endtask

  // Monitor: compare both clock phases against the queued item.
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      e = q.pop_front();
      @(posedge ref_clk); #2;
      check({e.req, " sdr high"}, 32'(sdr_clk), 32'(e.sdr_hi));
      check({e.req, " true high"}, 32'(ddr_clk_t), 32'(e.t_hi));
      check({e.req, " comp high"}, 32'(ddr_clk_c), 32'(e.c_hi));
      check({e.req, " fb high"}, {30'd0, fb_ddr_clk, fb_sdr_clk}, {30'd0, e.fbd_hi, e.fbs_hi});
      check("R8 mode echo", 32'(mode_rd), 32'(mode_sel));
      @(negedge ref_clk); #2;
      check({e.req, " sdr low"}, 32'(sdr_clk), 32'd0);
      check({e.req, " true low"}, 32'(ddr_clk_t), 32'(e.t_lo));
      check({e.req, " comp low"}, 32'(ddr_clk_c), 32'(e.c_lo));
      check({e.req, " fb low"}, {30'd0, fb_ddr_clk, fb_sdr_clk}, 32'd0);
      popped++;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7: enables cleared but reset held, so the selected bank runs fully
    drive(1'b1, '0, '0, 1'b1, "R7 reset ddr");
    drive(1'b0, '0, '0, 1'b1, "R7 reset sdr");
    @(negedge ref_clk); rst_n = 1'b1;
    // R7: still forced during the release cycles (sampled before the second edge)
    @(posedge ref_clk); #2;
    check("R7 release window", 32'(sdr_clk), 32'h1fff);
    repeat (3) @(posedge ref_clk);
    // R1 / R3 / R9 / R6: DDR mode, assorted enable patterns
    drive(1'b1, 13'h1fff, 6'b101101, 1'b0, "R1 R3 ddr pattern A");
    drive(1'b1, 13'h0aaa, 6'b111111, 1'b0, "R6 R3 ddr all on");
    drive(1'b1, 13'h1fff, 6'b000000, 1'b0, "R5 R4 ddr all off");
    // R2 / R9: SDR mode
    drive(1'b0, 13'h1555, 6'b111111, 1'b0, "R2 R9 sdr pattern A");
    drive(1'b0, 13'h0000, 6'b111111, 1'b0, "R5 R4 sdr all off");
    drive(1'b0, 13'h1fff, 6'b010010, 1'b0, "R2 sdr all on");
    // R4: clearing an enable mid high phase forces the output low with no edge
    @(posedge ref_clk); #1;
    check("R4 before clear", 32'(sdr_clk[12]), 32'd1);
    sdr_en[12] = 1'b0; #1;
    check("R4 async clear sdr", 32'(sdr_clk[12]), 32'd0);
    mode_sel = 1'b1; ddr_en = 6'b111111; #1;
    check("R8 mode echo async", 32'(mode_rd), 32'd1);
    check("R1 ddr true mid phase", 32'(ddr_clk_t), 32'h3f);
    ddr_en[3] = 1'b0; #1;
    check("R4 async clear ddr", 32'(ddr_clk_t), 32'h37);
    @(negedge ref_clk); #2;
    check("R4 R3 comp low phase", 32'(ddr_clk_c), 32'h37);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule